// File: doc/BRIEF.md
# Four-Channel Rotating-Priority DMA Request Arbiter

This block decides which of four DMA channels is served next. A channel can ask for service in two ways. It can raise its hardware request line, or the CPU can set the channel's software request bit. A software bit counts only while that channel is configured for block mode. It is never subject to a mask. The arbiter grants one channel at a time and holds the grant until the transfer engine reports that the service has ended. The grant is a one-hot vector, a channel index and a valid flag.

The priority order rotates. When a service ends, the channel just served drops to the lowest priority, and the channel numbered after it becomes the highest. Because of this, a channel that keeps asking is served after no more than three services to other channels.

The control is a two-state machine:
- `ARB_IDLE` waits for any effective request. The transition *take* moves to `ARB_BUSY` and latches the channel picked.
- `ARB_BUSY` drives the grant. The transition *release* fires on service done or on external end-of-process. It returns to `ARB_IDLE` and rotates the priority.

Every service is therefore followed by at least one idle cycle.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `gnt`, `gnt_idx`, `gnt_vld` and `sw_pend` are all zero, and channel 0 holds the highest priority.
- R2: A channel's effective request is `hw_req[c] | (sw_pend[c] & blk_mode[c])`. A software bit on a channel whose `blk_mode` bit is 0 is never granted. No input masks a software bit.
- R3: In `ARB_IDLE`, if any effective request is present at a clock edge, then from the next cycle:
  - `gnt_vld` is 1;
  - `gnt` is one-hot on the chosen channel;
  - `gnt_idx` equals that channel's number.
  
  The grant stays unchanged until `svc_done` or `ext_eop`.
- R4: The granted channel is the first one with an effective request, searching upward (modulo 4) from the highest-priority channel. When a service ends, the highest-priority channel becomes the served channel plus one, modulo 4.
- R5: A channel whose effective request stays asserted is granted after at most three grants to other channels.
- R6: A write with `cpu_wr` high changes exactly one bit of the software request register:
  - `cpu_wdata[1:0]` selects the channel;
  - `cpu_wdata[2]` gives the new value (1 sets, 0 clears).
  
  The new value appears on `sw_pend` one cycle later.
- R7: While a channel is granted, `svc_tc` or `ext_eop` clears that channel's software bit on the next edge. If a CPU write targets the same bit in the same cycle, the write wins.
- R8: `svc_done` or `ext_eop` in `ARB_BUSY` drops the grant on the next cycle. The next grant comes at the earliest one cycle later. `svc_done` without `svc_tc` leaves the software bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 4 | Hardware request per channel |
| blk_mode | input | 4 | Channel configured for block mode (enables its software bit) |
| cpu_wr | input | 1 | Software request register write strobe |
| cpu_wdata | input | 3 | Bit 2 set/clear, bits 1:0 channel |
| svc_done | input | 1 | Granted service finished |
| svc_tc | input | 1 | Granted channel reached terminal count |
| ext_eop | input | 1 | External end-of-process |
| gnt | output | 4 | One-hot grant |
| gnt_idx | output | 2 | Granted channel number (0 when idle) |
| gnt_vld | output | 1 | A grant is active |
| sw_pend | output | 4 | Software request register |

## Verification
Each result has a fixed latency:
- A grant appears on the cycle after the edge at which an effective request is seen in `ARB_IDLE`.
- `sw_pend` reflects a write, terminal count or end-of-process one cycle after the edge.
- A grant disappears one cycle after the edge carrying done or end-of-process.

The bench drives inputs just after a falling edge. It advances a requirement-level model across the following rising edge and compares every output at the next falling edge. Each check therefore lands exactly on the cycle the result is due. Separately, it counts the grants other channels receive while a channel keeps requesting, and checks the bound of R5.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/sw_req_reg.sv
module sw_req_reg #(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [CH_W:0]   wdata,
    input  logic            clr_en,
    input  logic [CH_W-1:0] clr_ch,
    output logic [NCH-1:0]  pend
);
    logic [CH_W-1:0] wr_ch;
    logic            wr_set;
    logic [NCH-1:0]  pend_d;

    assign wr_ch  = wdata[CH_W-1:0];
    assign wr_set = wdata[CH_W];

    // clear from the service first, CPU write applied last so it wins
    always_comb begin
        pend_d = pend;
        if (clr_en) pend_d[clr_ch] = 1'b0;
        if (wr)     pend_d[wr_ch]  = wr_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_d;
    end

    assert_sw_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pend[$past(wr_ch)] == $past(wr_set)));

    assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr && (wr_ch == clr_ch))) |=> !pend[$past(clr_ch)]);
endmodule

// File: rtl/rot_pri_pick.sv
module rot_pri_pick #(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  req,
    input  logic [CH_W-1:0] hi,
    output logic            any,
    output logic [CH_W-1:0] pick
);
    logic [CH_W-1:0] cand;

    // scan from lowest priority to highest; the last hit is the winner
    always_comb begin
        any  = |req;
        pick = hi;
        cand = hi;
        for (int k = NCH - 1; k >= 0; k--) begin
            cand = hi + CH_W'(k);
            if (req[cand]) pick = cand;
        end
    end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
    import dma_arb_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any,
    input  logic [CH_W-1:0] pick,
    input  logic            done,
    input  logic            eop,
    output logic            busy,
    output logic [CH_W-1:0] cur,
    output logic [CH_W-1:0] hi
);
    arb_state_e      state_q, state_d;
    logic [CH_W-1:0] cur_q, cur_d;
    logic [CH_W-1:0] hi_q, hi_d;
    logic            release_ev;

    assign release_ev = done || eop;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            cur_q   <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            hi_q    <= hi_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        hi_d    = hi_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (any) begin
                    state_d = ARB_BUSY;
                    cur_d   = pick;
                end
            end
            ARB_BUSY: begin
                if (release_ev) begin
                    state_d = ARB_IDLE;
                    hi_d    = cur_q + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        busy = (state_q == ARB_BUSY);
        cur  = cur_q;
        hi   = hi_q;
    end

    assert_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && any) |=> busy);

    assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !release_ev) |=> (busy && $stable(cur_q)));

    assert_idle_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && release_ev) |=> !busy);

    assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && release_ev) |=> (hi_q == $past(cur_q) + 1'b1));
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  hw_req,
    input  logic [NCH-1:0]  blk_mode,
    input  logic            cpu_wr,
    input  logic [CH_W:0]   cpu_wdata,
    input  logic            svc_done,
    input  logic            svc_tc,
    input  logic            ext_eop,
    output logic [NCH-1:0]  gnt,
    output logic [CH_W-1:0] gnt_idx,
    output logic            gnt_vld,
    output logic [NCH-1:0]  sw_pend
);
    logic [NCH-1:0]  req_eff;
    logic            any;
    logic [CH_W-1:0] pick;
    logic            busy;
    logic [CH_W-1:0] cur;
    logic [CH_W-1:0] hi;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign req_eff[g] = hw_req[g] | (sw_pend[g] & blk_mode[g]);
        assign gnt[g]     = busy && (cur == CH_W'(g));
    end

    assign gnt_vld = busy;
    assign gnt_idx = busy ? cur : '0;

    sw_req_reg #(.NCH(NCH), .CH_W(CH_W)) u_swreq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cpu_wr),
        .wdata  (cpu_wdata),
        .clr_en (busy && (svc_tc || ext_eop)),
        .clr_ch (cur),
        .pend   (sw_pend)
    );

    rot_pri_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .req  (req_eff),
        .hi   (hi),
        .any  (any),
        .pick (pick)
    );

    arb_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .any   (any),
        .pick  (pick),
        .done  (svc_done),
        .eop   (ext_eop),
        .busy  (busy),
        .cur   (cur),
        .hi    (hi)
    );

    assert_gnt_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (gnt_vld == (|gnt)));

    assert_pick_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && any) |-> req_eff[pick]);
endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] hw_req, blk_mode;
    logic       cpu_wr;
    logic [2:0] cpu_wdata;
    logic       svc_done, svc_tc, ext_eop;
    logic [3:0] gnt;
    logic [1:0] gnt_idx;
    logic       gnt_vld;
    logic [3:0] sw_pend;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // model state
    bit       m_busy;
    int       m_cur, m_hi;
    bit [3:0] m_sw;
    int       waitc [4];

    always #10 clk = ~clk;

    dma_req_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .blk_mode(blk_mode),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .svc_done(svc_done),
        .svc_tc(svc_tc), .ext_eop(ext_eop), .gnt(gnt), .gnt_idx(gnt_idx),
        .gnt_vld(gnt_vld), .sw_pend(sw_pend)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pick_ch(int hi, bit [3:0] eff);
        for (int k = 0; k < 4; k++)
            if (eff[(hi + k) % 4]) return (hi + k) % 4;
        return hi;
    endfunction

    task automatic check_outs();
        bit [3:0] eg;
        eg = m_busy ? (4'b1 << m_cur) : 4'b0;
        chk(gnt_vld == m_busy, "R3 gnt_vld", gnt_vld, m_busy);
        chk(gnt == eg, "R4 gnt", gnt, eg);
        chk(gnt_idx == (m_busy ? m_cur : 0), "R4 gnt_idx", gnt_idx, m_busy ? m_cur : 0);
        chk(sw_pend == m_sw, "R6/R7 sw_pend", sw_pend, m_sw);
    endtask

    // one cycle: inputs driven now (after falling edge), model advanced, compare next falling edge
    task automatic cyc(bit [3:0] hw, bit [3:0] blk, bit wr, bit [2:0] wd,
                       bit dn, bit tc, bit ep);
        bit [3:0] eff;
        bit [3:0] sw_n;
        int       k;
        hw_req = hw; blk_mode = blk; cpu_wr = wr; cpu_wdata = wd;
        svc_done = dn; svc_tc = tc; ext_eop = ep;
        eff  = hw | (m_sw & blk);
        sw_n = m_sw;
        if (m_busy && (tc || ep)) sw_n[m_cur] = 1'b0;
        if (wr) sw_n[wd[1:0]] = wd[2];
        for (int c = 0; c < 4; c++) if (!eff[c]) waitc[c] = 0;
        if (!m_busy) begin
            if (eff != 0) begin
                k = pick_ch(m_hi, eff);
                for (int c = 0; c < 4; c++) begin
                    if (c == k) waitc[c] = 0;
                    else if (eff[c]) begin
                        waitc[c]++;
                        chk(waitc[c] <= 3, "R5 wait bound", waitc[c], 3);
                    end
                end
                m_busy = 1; m_cur = k;
            end
        end else if (dn || ep) begin
            m_busy = 0; m_hi = (m_cur + 1) % 4;
        end
        m_sw = sw_n;
        @(negedge clk);
        check_outs();
    endtask

    // watchdog
    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int       seed;
        bit [3:0] hw, blk;
        rst_n = 1'b0; hw_req = 0; blk_mode = 0; cpu_wr = 0; cpu_wdata = 0;
        svc_done = 0; svc_tc = 0; ext_eop = 0;
        m_busy = 0; m_cur = 0; m_hi = 0; m_sw = 0;
        for (int c = 0; c < 4; c++) waitc[c] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(gnt == 0 && gnt_vld == 0 && gnt_idx == 0 && sw_pend == 0, "R1 reset outputs",
            {gnt, gnt_idx, gnt_vld, sw_pend}, 0);
        rst_n = 1'b1;

        // R1: all request after reset -> channel 0 first
        cyc(4'hF, 0, 0, 0, 0, 0, 0);
        chk(gnt_idx == 0, "R1 first grant ch0", gnt_idx, 0);
        cyc(4'hF, 0, 0, 0, 1, 0, 0);
        // R4: rotating order 1,2,3,0
        for (int i = 0; i < 4; i++) begin
            cyc(4'hF, 0, 0, 0, 0, 0, 0);
            chk(gnt_idx == (i + 1) % 4, "R4 rotation order", gnt_idx, (i + 1) % 4);
            cyc(4'hF, 0, 0, 0, 1, 0, 0);
            chk(gnt_vld == 0, "R8 idle gap", gnt_vld, 0);
        end
        // hi is now 1
        // R2: software bit on ch2 without block mode is ignored
        cyc(0, 0, 1, 3'b110, 0, 0, 0);
        repeat (4) begin
            cyc(0, 4'b1011, 0, 0, 0, 0, 0);
            chk(gnt_vld == 0, "R2 no grant without block mode", gnt_vld, 0);
        end
        // block mode enables it
        cyc(0, 4'b0100, 0, 0, 0, 0, 0);
        chk(gnt_idx == 2 && gnt_vld, "R2 sw request granted", gnt_idx, 2);
        // R8: done without tc keeps bit
        cyc(0, 4'b0100, 0, 0, 1, 0, 0);
        chk(sw_pend[2] == 1, "R8 done keeps sw bit", sw_pend, 4'b0100);
        cyc(0, 4'b0100, 0, 0, 0, 0, 0);
        // R7: tc with done clears
        cyc(0, 4'b0100, 0, 0, 1, 1, 0);
        chk(sw_pend == 0, "R7 tc clears sw bit", sw_pend, 0);
        // R7: eop clears and ends
        cyc(0, 4'hF, 1, 3'b101, 0, 0, 0);
        cyc(0, 4'hF, 0, 0, 0, 0, 0);
        chk(gnt_idx == 1, "R7 sw ch1 granted", gnt_idx, 1);
        cyc(0, 4'hF, 0, 0, 0, 0, 1);
        chk(sw_pend == 0 && gnt_vld == 0, "R7 eop clears and releases", {sw_pend, gnt_vld}, 0);
        // R7: same-cycle write wins over tc
        cyc(0, 4'hF, 1, 3'b111, 0, 0, 0);
        cyc(0, 4'hF, 0, 0, 0, 0, 0);
        chk(gnt_idx == 3, "R7 sw ch3 granted", gnt_idx, 3);
        cyc(0, 4'hF, 1, 3'b111, 1, 1, 0);
        chk(sw_pend[3] == 1, "R7 write wins over tc", sw_pend, 4'b1000);
        // R6: clear write touches only its bit
        cyc(0, 0, 1, 3'b100, 0, 0, 0);
        cyc(0, 0, 1, 3'b011, 0, 0, 0);
        chk(sw_pend == 4'b0001, "R6 single-bit write", sw_pend, 4'b0001);
        cyc(0, 0, 1, 3'b000, 0, 0, 0);

        // constrained random
        seed = $urandom(32'h5EED);
        hw = 0; blk = 0;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 8) == 0) hw  = 4'($urandom);
            if (($urandom % 16) == 0) blk = 4'($urandom);
            cyc(hw, blk, ($urandom % 6) == 0, 3'($urandom),
                ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 12) == 0);
        end
        // R5: all channels requesting, long run
        for (int i = 0; i < 40; i++)
            cyc(4'hF, 0, 0, 0, i % 2 == 1, 0, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule